// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a synthesizable behavioural model of a synchronous static RAM with registered inputs, a registered read path and a four-beat burst address generator. Every control input is sampled on the rising clock edge. Two address strobes start a burst at the external address: a processor-side strobe and a controller-side strobe. An advance strobe steps the burst on to the next address. If neither strobe nor advance is active, the burst holds its current address.

Three chip enables gate selection. A write decoder combines a global write strobe with a byte-write enable and per-lane strobes. Each lane carries 8 data bits plus one parity bit.

Read data comes out one cycle after the cycle that issued the read. The model has no tri-state pins. A drive indication stands in for them: it is gated asynchronously by an output-enable input, and it turns off two cycles after a deselect.

Top module: `burst_sram_core`

## Requirements
- R1: The core counts as selected only when `sel_n`=0, `sel2_n`=0 and `sel_hi`=1. A cycle that would start a burst under any other enable combination deselects the core: it performs no write and produces no read data.
- R2: A low `strb_cpu_n` is ignored while `sel_n`=1. The cycle is then decided by the other strobes. A low `strb_ctl_n` while `sel_n`=1 deselects the core.
- R3: A burst started by `strb_cpu_n` (with `sel_n`=0) is always a read at `addr`, even when the write strobes are active.
- R4: A burst started by `strb_ctl_n` (with `strb_cpu_n`=1) is a read or a write at `addr`, as chosen by the decoded write.
- R5: The decoded write is active when `wr_all_n`=0, or when `wr_bytes_n`=0 and any `lane_n` bit is 0. With `wr_all_n`=0 every lane is written. Otherwise only the lanes whose `lane_n` bit is 0 are written. Lane i occupies data bits [9i+8:9i]. If `wr_bytes_n`=0 and all `lane_n` bits are 1, the cycle is a read.
- R6: Once deselected, the core stays deselected until a cycle starts a burst. While deselected, advance and hold cycles neither write nor read.
- R7: The two low address bits form the burst. Each advance (`adv_n`=0) moves to the next beat. With `burst_linear`=1, beat n uses (start+n) mod 4. With `burst_linear`=0, beat n uses start XOR n. The upper address bits stay fixed. A hold cycle reuses the current address. After four beats the sequence returns to the start.
- R8: A read issued at clock edge k drives `rdata` and raises `rdata_oe` after edge k+1. `rdata_oe` is not raised after edge k by that read.
- R9: After a deselect at edge k, the last read before it still drives after edge k. `rdata_oe` is low after edge k+1.
- R10: `oe_n`=1 forces `rdata_oe` low at once, without waiting for a clock edge. Returning `oe_n` to 0 restores the drive at once.
- R11: Write data is sampled on the same edge as the beat's address. A read issued on the edge right after a write to the same address returns the new data.
- R12: After reset the core is deselected and `rdata_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | External word address |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| sel_n | input | 1 | Primary chip enable, active low |
| sel2_n | input | 1 | Second chip enable, active low |
| sel_hi | input | 1 | Third chip enable, active high |
| wr_all_n | input | 1 | Global write strobe, active low |
| wr_bytes_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES | Per-lane write strobes, active low |
| burst_linear | input | 1 | Burst order: 1 linear, 0 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Registered read data |
| rdata_oe | output | 1 | High when the read data would drive the bus |

## Verification
The bench builds the core with its defaults: 64 words in four 9-bit lanes. Six address bits leave four upper bits free. Bursts on different bases therefore never overlap, and each burst wrap stays visibly inside its own group of four words.

Four lanes allow a mask that writes alternate lanes. The merged word then shows every lane boundary, parity bit included. The small depth keeps the bench's shadow copy of the array cheap, so every read is compared against it.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL    = 3'd0,
    CMD_BEGIN_RD = 3'd1,
    CMD_BEGIN_WR = 3'd2,
    CMD_CONT     = 3'd3,
    CMD_SUSP     = 3'd4
  } bsr_cmd_e;

  // Low address bits of a burst beat, from start offset and beat index
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] step,
                                          input logic       linear);
    return linear ? (start + step) : (start ^ step);
  endfunction

endpackage

// File: rtl/bsr_cmd_decode.sv
module bsr_cmd_decode
  import bsr_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             strb_cpu_n,
  input  logic             strb_ctl_n,
  input  logic             adv_n,
  input  logic             sel_n,
  input  logic             sel2_n,
  input  logic             sel_hi,
  input  logic             wr_all_n,
  input  logic             wr_bytes_n,
  input  logic [LANES-1:0] lane_n,
  output bsr_cmd_e         cmd,
  output logic             wr_req,
  output logic [LANES-1:0] lane_we
);

  logic sel_all;
  logic cpu_seen;

  assign sel_all  = !sel_n && !sel2_n && sel_hi;
  assign cpu_seen = !strb_cpu_n && !sel_n;

  assign wr_req  = !wr_all_n || (!wr_bytes_n && (|(~lane_n)));
  assign lane_we = !wr_all_n ? {LANES{1'b1}} :
                   (wr_bytes_n ? {LANES{1'b0}} : ~lane_n);

  always_comb begin
    if (cpu_seen)
      cmd = sel_all ? CMD_BEGIN_RD : CMD_DESEL;
    else if (!strb_ctl_n)
      cmd = !sel_all ? CMD_DESEL : (wr_req ? CMD_BEGIN_WR : CMD_BEGIN_RD);
    else if (!adv_n)
      cmd = CMD_CONT;
    else
      cmd = CMD_SUSP;
  end

endmodule

// File: rtl/bsr_burst_ctr.sv
module bsr_burst_ctr
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bsr_cmd_e          cmd,
  input  logic              active,
  input  logic              linear,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] beat_addr
);

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        step;
  logic              starting;

  assign starting = (cmd == CMD_BEGIN_RD) || (cmd == CMD_BEGIN_WR);
  assign step     = (cmd == CMD_CONT) ? cnt_q + 2'd1 : cnt_q;

  assign beat_addr = starting ? ext_addr :
                     {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], step, linear)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (starting) begin
      base_q <= ext_addr;
      cnt_q  <= '0;
    end else if (active && cmd == CMD_CONT) begin
      cnt_q  <= step;
    end
  end

endmodule

// File: rtl/bsr_lane_array.sv
module bsr_lane_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          we,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [LANES*LANE_W-1:0]   rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we[g])
        mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      if (rd_en)
        q <= mem[rd_addr];
    end

    assign rd_data[g*LANE_W +: LANE_W] = q;
  end

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    strb_cpu_n,
  input  logic                    strb_ctl_n,
  input  logic                    adv_n,
  input  logic                    sel_n,
  input  logic                    sel2_n,
  input  logic                    sel_hi,
  input  logic                    wr_all_n,
  input  logic                    wr_bytes_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic                    burst_linear,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DW = LANES * LANE_W;

  bsr_cmd_e          cmd;
  logic              wr_req;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] beat_addr;

  // Named events, also observed by the bound checker
  logic active_q;
  logic evt_begin;
  logic evt_desel;
  logic flow;
  logic beat_rd;
  logic beat_wr;
  logic rd_pend_q;
  logic out_drv_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DW-1:0]     rd_word;

  bsr_cmd_decode #(.LANES(LANES)) i_dec (
    .strb_cpu_n (strb_cpu_n),
    .strb_ctl_n (strb_ctl_n),
    .adv_n      (adv_n),
    .sel_n      (sel_n),
    .sel2_n     (sel2_n),
    .sel_hi     (sel_hi),
    .wr_all_n   (wr_all_n),
    .wr_bytes_n (wr_bytes_n),
    .lane_n     (lane_n),
    .cmd        (cmd),
    .wr_req     (wr_req),
    .lane_we    (lane_we)
  );

  assign evt_begin = (cmd == CMD_BEGIN_RD) || (cmd == CMD_BEGIN_WR);
  assign evt_desel = (cmd == CMD_DESEL);
  assign flow      = active_q && ((cmd == CMD_CONT) || (cmd == CMD_SUSP));
  assign beat_wr   = (cmd == CMD_BEGIN_WR) || (flow && wr_req);
  assign beat_rd   = (cmd == CMD_BEGIN_RD) || (flow && !wr_req);

  bsr_burst_ctr #(.ADDR_W(ADDR_W)) i_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .active    (active_q),
    .linear    (burst_linear),
    .ext_addr  (addr),
    .beat_addr (beat_addr)
  );

  bsr_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_arr (
    .clk     (clk),
    .we      (beat_wr ? lane_we : {LANES{1'b0}}),
    .wr_addr (beat_addr),
    .wdata   (wdata),
    .rd_en   (rd_pend_q),
    .rd_addr (rd_addr_q),
    .rd_data (rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_addr_q <= '0;
      out_drv_q <= 1'b0;
    end else begin
      if (evt_begin)
        active_q <= 1'b1;
      else if (evt_desel)
        active_q <= 1'b0;
      rd_pend_q <= beat_rd;
      rd_addr_q <= beat_addr;
      out_drv_q <= rd_pend_q;
    end
  end

  assign rdata    = rd_word;
  assign rdata_oe = out_drv_q && !oe_n;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker (
  input logic clk,
  input logic rst_n,
  input logic strb_cpu_n,
  input logic strb_ctl_n,
  input logic sel_n,
  input logic sel2_n,
  input logic sel_hi,
  input logic active_q,
  input logic evt_begin,
  input logic evt_desel,
  input logic beat_rd,
  input logic beat_wr,
  input logic out_drv_q
);

  // R1: a strobe seen without full selection leaves the core deselected
  a_r1_partial_select_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    ((!strb_ctl_n || (!strb_cpu_n && !sel_n)) && !(!sel_n && !sel2_n && sel_hi))
      |=> !active_q);

  // R2: processor strobe with the primary enable high is ignored
  a_r2_cpu_strobe_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && sel_n && strb_ctl_n) |-> (!evt_begin && !evt_desel));

  // R3: a selected processor-strobe begin is always a read
  a_r3_cpu_begin_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !sel_n && !sel2_n && sel_hi) |-> (beat_rd && !beat_wr));

  // R6: no access while deselected, and no reselection without a begin
  a_r6_idle_no_access: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !evt_begin) |-> (!beat_rd && !beat_wr));

  a_r6_stays_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !evt_begin) |=> !active_q);

  // R8: a read drives the bus two edges after it is issued
  a_r8_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    beat_rd |=> ##1 out_drv_q);

  // R9: without a read the drive is gone two edges later
  a_r9_double_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_rd |=> ##1 !out_drv_q);

endmodule

bind burst_sram_core bsr_checker i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strb_cpu_n (strb_cpu_n),
  .strb_ctl_n (strb_ctl_n),
  .sel_n      (sel_n),
  .sel2_n     (sel2_n),
  .sel_hi     (sel_hi),
  .active_q   (active_q),
  .evt_begin  (evt_begin),
  .evt_desel  (evt_desel),
  .beat_rd    (beat_rd),
  .beat_wr    (beat_wr),
  .out_drv_q  (out_drv_q)
);

// File: tb/test_burst_sram_core.sv
`timescale 1ns/1ps
module test_burst_sram_core;

  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr;
  logic strb_cpu_n, strb_ctl_n, adv_n, sel_n, sel2_n, sel_hi;
  logic wr_all_n, wr_bytes_n, burst_linear, oe_n;
  logic [NL-1:0] lane_n;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [1 << AW];

  always #4 clk = ~clk;

  burst_sram_core #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) i_burst_sram_core (
    .clk(clk), .rst_n(rst_n), .addr(addr), .strb_cpu_n(strb_cpu_n),
    .strb_ctl_n(strb_ctl_n), .adv_n(adv_n), .sel_n(sel_n), .sel2_n(sel2_n),
    .sel_hi(sel_hi), .wr_all_n(wr_all_n), .wr_bytes_n(wr_bytes_n),
    .lane_n(lane_n), .burst_linear(burst_linear), .oe_n(oe_n),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic set_idle();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    sel_n = 0; sel2_n = 0; sel_hi = 1;
    wr_all_n = 1; wr_bytes_n = 1; lane_n = '1;
    addr = '0; wdata = '0; oe_n = 0;
  endtask

  task automatic cmd_desel();
    set_idle();
    strb_ctl_n = 0; sel_n = 1;
  endtask

  // Lane i covers bits [9i+8:9i]
  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w,
                                          input logic [DW-1:0] new_w,
                                          input logic [NL-1:0] ln);
    logic [DW-1:0] r = old_w;
    for (int i = 0; i < NL; i++)
      if (!ln[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
    return r;
  endfunction

  task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input logic global, input logic [NL-1:0] ln);
    set_idle();
    strb_ctl_n = 0; addr = a; wdata = d;
    if (global) wr_all_n = 0;
    else begin wr_bytes_n = 0; lane_n = ln; end
    model[a] = global ? d : merge(model[a], d, ln);
    tick();
    cmd_desel();
    tick();
  endtask

  task automatic read_word(input logic [AW-1:0] a, input string req);
    set_idle();
    strb_cpu_n = 0; addr = a;
    tick();
    chk({req, " R8 not yet driven"}, DW'(rdata_oe), '0);
    cmd_desel();
    tick();
    chk({req, " R8 drive"}, DW'(rdata_oe), 1);
    chk({req, " data"}, rdata, model[a]);
    tick();
    chk({req, " R9 off"}, DW'(rdata_oe), '0);
  endtask

  task automatic t_reset();
    chk("R12 reset drive", DW'(rdata_oe), '0);
    tick();
    chk("R12 idle after reset", DW'(rdata_oe), '0);
  endtask

  task automatic t_global_write();
    write_word(6'd5, 36'hA_1111_2222, 1, '1);
    read_word(6'd5, "R4 ctl write");
  endtask

  task automatic t_byte_write();
    write_word(6'd5, 36'h5_AAAA_BBBB, 0, 4'b1010);
    read_word(6'd5, "R5 lanes 0,2");
    set_idle();
    strb_ctl_n = 0; addr = 6'd5; wr_bytes_n = 0; lane_n = '1; wdata = 36'hF_FFFF_FFFF;
    tick();
    cmd_desel();
    tick();
    chk("R5 no-lane is read drive", DW'(rdata_oe), 1);
    chk("R5 no-lane is read data", rdata, model[5]);
    tick();
  endtask

  task automatic t_cpu_read();
    set_idle();
    strb_cpu_n = 0; wr_all_n = 0; addr = 6'd5; wdata = 36'h0_0000_0BAD;
    tick();
    cmd_desel();
    tick();
    chk("R3 cpu begin reads", rdata, model[5]);
    tick();
    read_word(6'd5, "R3 unchanged");
  endtask

  task automatic t_select();
    write_word(6'd7, 36'h3_CAFE_0077, 1, '1);
    set_idle(); strb_ctl_n = 0; sel_hi = 0; wr_all_n = 0; addr = 6'd7; wdata = '1;
    tick();
    set_idle(); strb_ctl_n = 0; sel2_n = 1; wr_all_n = 0; addr = 6'd7; wdata = '1;
    tick();
    chk("R1 no drive after partial select", DW'(rdata_oe), '0);
    set_idle(); strb_cpu_n = 0; sel2_n = 1; addr = 6'd7;
    tick();
    chk("R1 cpu partial select", DW'(rdata_oe), '0);
    tick();
    chk("R1 cpu partial select late", DW'(rdata_oe), '0);
    read_word(6'd7, "R1 unchanged");
    // deselect in the middle of an active read burst
    set_idle(); strb_cpu_n = 0; addr = 6'd7;
    tick();
    set_idle(); strb_cpu_n = 0; sel2_n = 1;
    tick();
    chk("R9 last read still drives", rdata, model[7]);
    set_idle(); adv_n = 0;
    tick();
    chk("R9 off two edges after deselect", DW'(rdata_oe), '0);
    tick();
    chk("R6 advance does not reselect", DW'(rdata_oe), '0);
  endtask

  task automatic t_cpu_ignored();
    write_word(6'h11, 36'h1_0000_0011, 1, '1);
    write_word(6'h12, 36'h1_0000_0012, 1, '1);
    burst_linear = 1;
    set_idle(); strb_cpu_n = 0; addr = 6'h11;
    tick();
    set_idle(); strb_cpu_n = 0; sel_n = 1; adv_n = 0; addr = 6'h30;
    tick();
    chk("R2 first beat", rdata, model[6'h11]);
    cmd_desel(); strb_cpu_n = 0;
    tick();
    chk("R2 ignored strobe advanced", rdata, model[6'h12]);
    chk("R2 drive", DW'(rdata_oe), 1);
    tick();
    chk("R2 ctl strobe deselects", DW'(rdata_oe), '0);
  endtask

  task automatic t_burst();
    logic [AW-1:0] wseq [5];
    logic [AW-1:0] rseq [5];
    wseq = '{6'h22, 6'h23, 6'h20, 6'h21, 6'h21};
    rseq = '{6'h21, 6'h20, 6'h23, 6'h22, 6'h21};
    burst_linear = 1;
    set_idle(); strb_ctl_n = 0; addr = 6'h22; wr_all_n = 0; wdata = 36'h2_0000_0000;
    model[wseq[0]] = wdata;
    tick();
    for (int i = 1; i < 5; i++) begin
      set_idle(); wr_all_n = 0; adv_n = (i == 4); wdata = 36'h2_0000_0000 + DW'(i);
      model[wseq[i]] = wdata;
      tick();
    end
    cmd_desel();
    tick();
    burst_linear = 0;
    set_idle(); strb_cpu_n = 0; addr = 6'h21;
    tick();
    for (int i = 1; i < 5; i++) begin
      set_idle(); adv_n = 0;
      tick();
      chk("R7 interleaved beat", rdata, model[rseq[i-1]]);
    end
    cmd_desel();
    tick();
    chk("R7 wrap to start", rdata, model[rseq[4]]);
    tick();
    chk("R7 done drive off", DW'(rdata_oe), '0);
    burst_linear = 1;
  endtask

  task automatic t_hold_desel();
    write_word(6'h31, 36'h4_0000_0031, 1, '1);
    write_word(6'h30, 36'h4_0000_0030, 1, '1);
    set_idle(); adv_n = 0; wr_all_n = 0; wdata = 36'hE_EEEE_EEEE;
    tick();
    chk("R6 deselected advance", DW'(rdata_oe), '0);
    set_idle(); wr_all_n = 0; wdata = 36'hD_DDDD_DDDD;
    tick();
    chk("R6 deselected hold", DW'(rdata_oe), '0);
    tick();
    chk("R6 still no drive", DW'(rdata_oe), '0);
    read_word(6'h30, "R6 no write base");
    read_word(6'h31, "R6 no write next");
  endtask

  task automatic t_oe();
    set_idle(); strb_cpu_n = 0; addr = 6'h30;
    tick();
    cmd_desel(); oe_n = 1;
    tick();
    chk("R10 oe high blocks", DW'(rdata_oe), '0);
    oe_n = 0;
    #1;
    chk("R10 oe low restores", DW'(rdata_oe), 1);
    chk("R10 data", rdata, model[6'h30]);
    tick();
  endtask

  task automatic t_back_to_back();
    set_idle(); strb_ctl_n = 0; addr = 6'h3A; wr_all_n = 0; wdata = 36'h7_1357_9BDF;
    model[6'h3A] = wdata;
    tick();
    set_idle(); strb_cpu_n = 0; addr = 6'h3A;
    tick();
    cmd_desel();
    tick();
    chk("R11 read after write", rdata, model[6'h3A]);
    tick();
  endtask

  initial begin
    set_idle();
    burst_linear = 1;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1;
    t_reset();
    t_global_write();
    t_byte_write();
    t_cpu_read();
    t_select();
    t_cpu_ignored();
    t_burst();
    t_hold_desel();
    t_oe();
    t_back_to_back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule